// File: doc/BRIEF.md
# USB Device IN Transaction Handler

This block runs the device side of IN transactions for a full-speed USB endpoint engine. A packet receiver hands it token packets that are already decoded into a packet identifier, a device address and an endpoint number. When a token is an IN token aimed at this device and at an enabled endpoint, the block answers in one of two ways. If the endpoint buffer holds data, it starts a data phase. If the buffer is empty, it starts a NAK handshake. A token that fails any of these checks gets no answer at all.

After a data phase on a normal endpoint, the block waits a bounded time for the host's ACK. Only an ACK marks the buffer empty, flips the endpoint's DATA0/DATA1 toggle and raises that endpoint's interrupt bit. Isochronous endpoints have no handshake phase. For them the same update happens as soon as the transmitter reports that the data phase is out, and they always send DATA0.

A local processor sees one pending bit per endpoint and an interrupt line that is their OR. It clears bits by writing ones. It marks a buffer full again after refilling it, so that the data goes out on the next IN token.

Top module: `usbd_in_engine`

## Requirements
- R1: Only a token whose PID is IN (4'b1001) is acted on. Any other token PID produces no response.
- R2: An IN token whose address differs from `dev_addr` produces no response.
- R3: An IN token to an endpoint whose `ep_enable` bit is 0 produces no response.
- R4: An IN token to an enabled endpoint whose buffer is full pulses `tx_start` in the cycle after the token, with `tx_ep` set to the endpoint. `tx_pid` is DATA0 (4'b0011) when the endpoint toggle is 0 and DATA1 (4'b1011) when it is 1.
- R5: An IN token to an enabled endpoint whose buffer is empty pulses `tx_start` with `tx_pid` = NAK (4'b1010).
- R6: On a non-isochronous endpoint, an ACK (hs_pid 4'b0010) that arrives after `tx_done` does three things in the cycle after the ACK: it clears the endpoint's `ep_full` bit, sets its `irq_pend` bit and flips its toggle.
- R7: On an isochronous endpoint, `tx_done` clears `ep_full` and sets `irq_pend` in the next cycle without any handshake. The data PID is always DATA0, and a later handshake has no effect.
- R8: An ACK is accepted on any of the first HS_BITS*BIT_CLKS clock edges after the `tx_done` edge. If no ACK arrives in that window, `ep_full`, `irq_pend` and the toggle keep their values, and the next IN sends the same data PID again.
- R9: A handshake other than ACK in the wait window ends the transaction and leaves the endpoint state unchanged.
- R10: `irq` is high exactly when any `irq_pend` bit is set. A 1 in `irq_clr` clears that bit, but a set in the same cycle takes precedence.
- R11: `fill_valid` marks the buffer of `fill_ep` full in the next cycle.
- R12: A token that arrives while a transaction is still in progress produces no response.
- R13: After reset, all buffers are empty, all toggles are 0, no bit is pending, `irq` is low and `tx_start` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_addr | input | ADDR_W | Configured device address |
| ep_enable | input | NUM_EP | Per-endpoint enable |
| ep_iso | input | NUM_EP | Per-endpoint isochronous flag |
| tok_valid | input | 1 | Token strobe from the packet receiver |
| tok_pid | input | 4 | Token packet identifier |
| tok_addr | input | ADDR_W | Token device address |
| tok_ep | input | EP_W | Token endpoint number |
| tx_start | output | 1 | One-cycle request to the transmitter |
| tx_pid | output | 4 | PID to send (DATA0, DATA1 or NAK) |
| tx_ep | output | EP_W | Endpoint whose buffer is sent |
| tx_done | input | 1 | Transmitter finished the data phase |
| hs_valid | input | 1 | Handshake packet strobe from the host |
| hs_pid | input | 4 | Handshake packet identifier |
| fill_valid | input | 1 | Processor marks a buffer full |
| fill_ep | input | EP_W | Endpoint refilled |
| irq_clr | input | NUM_EP | Write-one-to-clear for pending bits |
| ep_full | output | NUM_EP | Buffer-full status per endpoint |
| irq_pend | output | NUM_EP | Interrupt pending per endpoint |
| irq | output | 1 | Interrupt to the processor |

## Verification
The toggle bit is internal, so a toggle corrupted by a dropped or doubled flip shows up only at the next data phase on that endpoint: `tx_pid` carries the wrong DATA PID one cycle after the following IN token. A wrong transaction state is visible sooner. A stuck wait state swallows the next token, and a missed isochronous or ACK commit leaves `ep_full` and `irq_pend` wrong one cycle after `tx_done` or the ACK. The timeout window is probed on both sides of its last accepted edge, so an off-by-one counter changes whether the buffer empties.

// File: rtl/usbd_in_pkg.sv
package usbd_in_pkg;

    typedef logic [3:0] pid_t;

    localparam pid_t PID_IN    = 4'b1001;
    localparam pid_t PID_ACK   = 4'b0010;
    localparam pid_t PID_NAK   = 4'b1010;
    localparam pid_t PID_DATA0 = 4'b0011;
    localparam pid_t PID_DATA1 = 4'b1011;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_NAK  = 2'd1,
        RSP_DATA = 2'd2
    } resp_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SEND    = 2'd1,
        PH_WAIT_HS = 2'd2
    } phase_e;

    // Data PID for an endpoint: isochronous endpoints never alternate.
    function automatic pid_t data_pid(input logic toggle, input logic iso);
        return (toggle && !iso) ? PID_DATA1 : PID_DATA0;
    endfunction

endpackage

// File: rtl/usbd_tok_match.sv
module usbd_tok_match
    import usbd_in_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int ADDR_W = 7,
    parameter int EP_W   = 4
) (
    input  logic              tok_valid,
    input  pid_t              tok_pid,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [NUM_EP-1:0] ep_enable,
    input  logic [NUM_EP-1:0] ep_full,
    input  logic [NUM_EP-1:0] ep_iso,
    input  logic [NUM_EP-1:0] ep_toggle,
    output resp_e             resp,
    output pid_t              rsp_pid,
    output logic              rsp_iso
);
    logic ep_in_range;
    logic accepted;
    logic sel_en, sel_full, sel_iso, sel_tog;

    always_comb begin
        ep_in_range = (32'(tok_ep) < NUM_EP);
        sel_en   = 1'b0;
        sel_full = 1'b0;
        sel_iso  = 1'b0;
        sel_tog  = 1'b0;
        if (ep_in_range) begin
            sel_en   = ep_enable[tok_ep];
            sel_full = ep_full[tok_ep];
            sel_iso  = ep_iso[tok_ep];
            sel_tog  = ep_toggle[tok_ep];
        end
        accepted = tok_valid && (tok_pid == PID_IN) && (tok_addr == dev_addr)
                   && ep_in_range && sel_en;
        rsp_iso  = sel_iso;
        if (!accepted) begin
            resp    = RSP_NONE;
            rsp_pid = PID_NAK;
        end else if (sel_full) begin
            resp    = RSP_DATA;
            rsp_pid = data_pid(sel_tog, sel_iso);
        end else begin
            resp    = RSP_NAK;
            rsp_pid = PID_NAK;
        end
    end
endmodule

// File: rtl/usbd_ep_table.sv
module usbd_ep_table
    import usbd_in_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int EP_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_valid,
    input  logic [EP_W-1:0]   fill_ep,
    input  logic              commit_valid,
    input  logic [EP_W-1:0]   commit_ep,
    input  logic              commit_iso,
    input  logic [NUM_EP-1:0] irq_clr,
    output logic [NUM_EP-1:0] ep_full,
    output logic [NUM_EP-1:0] ep_toggle,
    output logic [NUM_EP-1:0] irq_pend
);
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic hit_commit;
        logic hit_fill;

        assign hit_commit = commit_valid && (32'(commit_ep) == i);
        assign hit_fill   = fill_valid && (32'(fill_ep) == i);

        always_ff @(posedge clk) begin
            if (rst) begin
                ep_full[i]   <= 1'b0;
                ep_toggle[i] <= 1'b0;
                irq_pend[i]  <= 1'b0;
            end else begin
                // Refill after an empty commit in the same cycle leaves it full.
                if (hit_fill)
                    ep_full[i] <= 1'b1;
                else if (hit_commit)
                    ep_full[i] <= 1'b0;

                if (hit_commit && !commit_iso)
                    ep_toggle[i] <= ~ep_toggle[i];

                // A new event beats a simultaneous software clear.
                if (hit_commit)
                    irq_pend[i] <= 1'b1;
                else if (irq_clr[i])
                    irq_pend[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/usbd_in_fsm.sv
module usbd_in_fsm
    import usbd_in_pkg::*;
#(
    parameter int EP_W       = 4,
    parameter int HS_TIMEOUT = 72
) (
    input  logic            clk,
    input  logic            rst,
    input  resp_e           resp,
    input  pid_t            rsp_pid,
    input  logic            rsp_iso,
    input  logic [EP_W-1:0] tok_ep,
    input  logic            tx_done,
    input  logic            hs_valid,
    input  pid_t            hs_pid,
    output logic            tx_start,
    output pid_t            tx_pid,
    output logic [EP_W-1:0] tx_ep,
    output logic            commit_valid,
    output logic [EP_W-1:0] commit_ep,
    output logic            commit_iso
);
    localparam int CNT_W = $clog2(HS_TIMEOUT + 1);

    phase_e           phase;
    logic [CNT_W-1:0] hs_cnt;
    logic [EP_W-1:0]  cur_ep;
    logic             cur_iso;

    always_comb begin
        commit_ep    = cur_ep;
        commit_iso   = cur_iso;
        commit_valid = 1'b0;
        if (phase == PH_SEND && tx_done && cur_iso)
            commit_valid = 1'b1;
        else if (phase == PH_WAIT_HS && hs_valid && hs_pid == PID_ACK)
            commit_valid = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            hs_cnt   <= '0;
            cur_ep   <= '0;
            cur_iso  <= 1'b0;
            tx_start <= 1'b0;
            tx_pid   <= PID_NAK;
            tx_ep    <= '0;
        end else begin
            tx_start <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (resp != RSP_NONE) begin
                        tx_start <= 1'b1;
                        tx_pid   <= rsp_pid;
                        tx_ep    <= tok_ep;
                    end
                    if (resp == RSP_DATA) begin
                        phase   <= PH_SEND;
                        cur_ep  <= tok_ep;
                        cur_iso <= rsp_iso;
                    end
                end
                PH_SEND: begin
                    if (tx_done) begin
                        hs_cnt <= '0;
                        phase  <= cur_iso ? PH_IDLE : PH_WAIT_HS;
                    end
                end
                PH_WAIT_HS: begin
                    if (hs_valid)
                        phase <= PH_IDLE;
                    else if (32'(hs_cnt) == HS_TIMEOUT - 1)
                        phase <= PH_IDLE;
                    else
                        hs_cnt <= hs_cnt + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usbd_in_engine.sv
module usbd_in_engine
    import usbd_in_pkg::*;
#(
    parameter int NUM_EP   = 16,
    parameter int ADDR_W   = 7,
    parameter int BIT_CLKS = 4,
    parameter int HS_BITS  = 18,
    localparam int EP_W    = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [NUM_EP-1:0] ep_enable,
    input  logic [NUM_EP-1:0] ep_iso,
    input  logic              tok_valid,
    input  logic [3:0]        tok_pid,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    output logic              tx_start,
    output logic [3:0]        tx_pid,
    output logic [EP_W-1:0]   tx_ep,
    input  logic              tx_done,
    input  logic              hs_valid,
    input  logic [3:0]        hs_pid,
    input  logic              fill_valid,
    input  logic [EP_W-1:0]   fill_ep,
    input  logic [NUM_EP-1:0] irq_clr,
    output logic [NUM_EP-1:0] ep_full,
    output logic [NUM_EP-1:0] irq_pend,
    output logic              irq
);
    localparam int HS_TIMEOUT = BIT_CLKS * HS_BITS;

    resp_e             resp;
    pid_t              rsp_pid;
    logic              rsp_iso;
    logic [NUM_EP-1:0] ep_toggle;
    logic              commit_valid;
    logic [EP_W-1:0]   commit_ep;
    logic              commit_iso;

    usbd_tok_match #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .EP_W(EP_W)) u_match (
        .tok_valid (tok_valid),
        .tok_pid   (tok_pid),
        .tok_addr  (tok_addr),
        .tok_ep    (tok_ep),
        .dev_addr  (dev_addr),
        .ep_enable (ep_enable),
        .ep_full   (ep_full),
        .ep_iso    (ep_iso),
        .ep_toggle (ep_toggle),
        .resp      (resp),
        .rsp_pid   (rsp_pid),
        .rsp_iso   (rsp_iso)
    );

    usbd_in_fsm #(.EP_W(EP_W), .HS_TIMEOUT(HS_TIMEOUT)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .resp         (resp),
        .rsp_pid      (rsp_pid),
        .rsp_iso      (rsp_iso),
        .tok_ep       (tok_ep),
        .tx_done      (tx_done),
        .hs_valid     (hs_valid),
        .hs_pid       (hs_pid),
        .tx_start     (tx_start),
        .tx_pid       (tx_pid),
        .tx_ep        (tx_ep),
        .commit_valid (commit_valid),
        .commit_ep    (commit_ep),
        .commit_iso   (commit_iso)
    );

    usbd_ep_table #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_table (
        .clk          (clk),
        .rst          (rst),
        .fill_valid   (fill_valid),
        .fill_ep      (fill_ep),
        .commit_valid (commit_valid),
        .commit_ep    (commit_ep),
        .commit_iso   (commit_iso),
        .irq_clr      (irq_clr),
        .ep_full      (ep_full),
        .ep_toggle    (ep_toggle),
        .irq_pend     (irq_pend)
    );

    assign irq = |irq_pend;
endmodule

// File: rtl/usbd_in_engine_chk.sv
module usbd_in_engine_chk
    import usbd_in_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int ADDR_W = 7,
    parameter int EP_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] dev_addr,
    input logic [NUM_EP-1:0] ep_enable,
    input logic [NUM_EP-1:0] ep_iso,
    input logic              tok_valid,
    input logic [3:0]        tok_pid,
    input logic [ADDR_W-1:0] tok_addr,
    input logic [EP_W-1:0]   tok_ep,
    input logic              tx_start,
    input logic [3:0]        tx_pid,
    input logic [NUM_EP-1:0] ep_full,
    input logic [NUM_EP-1:0] irq_pend,
    input logic [NUM_EP-1:0] irq_clr
);
    // R1: a response is always caused by an IN token one cycle earlier
    p_start_needs_in_r1: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(tok_valid && tok_pid == PID_IN));

    // R2: a response only follows a token carrying our address
    p_addr_match_r2: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(tok_addr == dev_addr));

    // R3: a response only follows a token to an enabled endpoint
    p_enabled_only_r3: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(ep_enable[tok_ep]));

    // R5: a NAK is sent only for an empty buffer
    p_nak_when_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_start && tx_pid == PID_NAK) |-> !$past(ep_full[tok_ep]));

    // R7: isochronous endpoints always answer with DATA0
    p_iso_data0_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_start && tx_pid != PID_NAK && $past(ep_iso[tok_ep])) |-> tx_pid == PID_DATA0);

    // R10: a pending bit only drops when software asked to clear it
    p_pend_drop_on_clear_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(irq_pend) & ~$past(irq_clr) & ~irq_pend) == '0));
endmodule

bind usbd_in_engine usbd_in_engine_chk #(
    .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .EP_W(EP_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dev_addr  (dev_addr),
    .ep_enable (ep_enable),
    .ep_iso    (ep_iso),
    .tok_valid (tok_valid),
    .tok_pid   (tok_pid),
    .tok_addr  (tok_addr),
    .tok_ep    (tok_ep),
    .tx_start  (tx_start),
    .tx_pid    (tx_pid),
    .ep_full   (ep_full),
    .irq_pend  (irq_pend),
    .irq_clr   (irq_clr)
);

// File: tb/usbd_in_engine_tb.sv
module usbd_in_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_EP     = 16;
    localparam int ADDR_W     = 7;
    localparam int EP_W       = 4;
    localparam int HS_TO      = 4 * 18;

    localparam logic [3:0] P_IN = 4'b1001, P_OUT = 4'b0001, P_SETUP = 4'b1101;
    localparam logic [3:0] P_ACK = 4'b0010, P_NAK = 4'b1010;
    localparam logic [3:0] P_D0 = 4'b0011, P_D1 = 4'b1011;
    localparam logic [6:0] MY_ADDR = 7'h2A;

    // {token pid, address, endpoint, expect start, expected pid}
    localparam int NVEC = 8;
    localparam logic [19:0] VEC [NVEC] = '{
        {P_IN,    MY_ADDR, 4'd1, 1'b1, P_D0},
        {P_IN,    MY_ADDR, 4'd2, 1'b1, P_NAK},
        {P_IN,    7'h15,   4'd1, 1'b0, P_NAK},
        {P_OUT,   MY_ADDR, 4'd1, 1'b0, P_NAK},
        {P_SETUP, MY_ADDR, 4'd2, 1'b0, P_NAK},
        {P_IN,    MY_ADDR, 4'd9, 1'b0, P_NAK},
        {P_IN,    MY_ADDR, 4'd5, 1'b1, P_D0},
        {P_IN,    MY_ADDR, 4'd0, 1'b1, P_NAK}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] dev_addr = MY_ADDR;
    logic [NUM_EP-1:0] ep_enable = 16'h00FF;
    logic [NUM_EP-1:0] ep_iso = 16'h0040;
    logic              tok_valid = 1'b0;
    logic [3:0]        tok_pid = '0;
    logic [ADDR_W-1:0] tok_addr = '0;
    logic [EP_W-1:0]   tok_ep = '0;
    logic              tx_start;
    logic [3:0]        tx_pid;
    logic [EP_W-1:0]   tx_ep;
    logic              tx_done = 1'b0;
    logic              hs_valid = 1'b0;
    logic [3:0]        hs_pid = '0;
    logic              fill_valid = 1'b0;
    logic [EP_W-1:0]   fill_ep = '0;
    logic [NUM_EP-1:0] irq_clr = '0;
    logic [NUM_EP-1:0] ep_full;
    logic [NUM_EP-1:0] irq_pend;
    logic              irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbd_in_engine dut_i (
        .clk(clk), .rst(rst), .dev_addr(dev_addr), .ep_enable(ep_enable), .ep_iso(ep_iso),
        .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
        .tx_start(tx_start), .tx_pid(tx_pid), .tx_ep(tx_ep), .tx_done(tx_done),
        .hs_valid(hs_valid), .hs_pid(hs_pid), .fill_valid(fill_valid), .fill_ep(fill_ep),
        .irq_clr(irq_clr), .ep_full(ep_full), .irq_pend(irq_pend), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // All drivers start at a falling edge and return at the next one.
    task automatic send_tok(input logic [3:0] p, input logic [6:0] a, input logic [3:0] e);
        tok_valid = 1'b1; tok_pid = p; tok_addr = a; tok_ep = e;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic send_done();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic send_hs(input logic [3:0] p);
        hs_valid = 1'b1; hs_pid = p;
        @(negedge clk);
        hs_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [3:0] e);
        fill_valid = 1'b1; fill_ep = e;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_clr(input logic [15:0] m);
        irq_clr = m;
        @(negedge clk);
        irq_clr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R13: reset state
        chk("R13 ep_full", 32'(ep_full), 32'h0);
        chk("R13 irq_pend", 32'(irq_pend), 32'h0);
        chk("R13 irq/tx_start", {30'b0, irq, tx_start}, 32'h0);

        // R11: refill marks buffers full
        do_fill(4'd1);
        do_fill(4'd5);
        chk("R11 fill", 32'(ep_full), 32'h0022);

        // Table walk: R1, R2, R3, R4, R5, R9
        for (int i = 0; i < NVEC; i++) begin
            send_tok(VEC[i][19:16], VEC[i][15:9], VEC[i][8:5]);
            if (VEC[i][4])
                chk($sformatf("R4/R5 vec%0d", i), {27'b0, tx_start, tx_pid}, {27'b0, 1'b1, VEC[i][3:0]});
            else
                chk($sformatf("R1/R2/R3 vec%0d", i), 32'(tx_start), 32'h0);
            if (VEC[i][4] && VEC[i][3:0] != P_NAK) begin
                send_done();
                send_hs(P_NAK);
                chk($sformatf("R9 vec%0d", i), {16'(irq_pend), 16'(ep_full)}, {16'h0, 16'h0022});
            end
        end

        // R6: ACK empties, interrupts and toggles
        send_tok(P_IN, MY_ADDR, 4'd1);
        chk("R4 ep1 data0", {28'b0, tx_pid}, 32'(P_D0));
        send_done();
        send_hs(P_ACK);
        chk("R6 ep1 commit", {15'b0, irq, 16'(ep_full & 16'h0002)}, {15'b0, 1'b1, 16'h0});
        chk("R6 ep1 pend", 32'(irq_pend), 32'h0002);
        do_fill(4'd1);
        send_tok(P_IN, MY_ADDR, 4'd1);
        chk("R6 toggle DATA1", {27'b0, tx_start, tx_pid}, {27'b0, 1'b1, P_D1});
        send_done();
        send_hs(P_ACK);
        send_tok(P_IN, MY_ADDR, 4'd1);
        chk("R5 emptied NAK", {27'b0, tx_start, tx_pid}, {27'b0, 1'b1, P_NAK});

        // R10: write-one-to-clear
        do_clr(16'h0002);
        chk("R10 clear", {15'b0, irq, 16'(irq_pend)}, 32'h0);

        // R7: isochronous, no handshake, always DATA0
        do_fill(4'd6);
        send_tok(P_IN, MY_ADDR, 4'd6);
        chk("R7 iso data0", {27'b0, tx_start, tx_pid}, {27'b0, 1'b1, P_D0});
        send_done();
        chk("R7 iso commit", {16'(irq_pend), 16'(ep_full & 16'h0040)}, {16'h0040, 16'h0});
        send_hs(P_ACK);
        chk("R7 late ack ignored", 32'(ep_full & 16'h0040), 32'h0);
        do_fill(4'd6);
        send_tok(P_IN, MY_ADDR, 4'd6);
        chk("R7 iso still data0", {28'b0, tx_pid}, 32'(P_D0));
        // R10: set beats a clear in the same cycle
        tx_done = 1'b1; irq_clr = 16'h0040;
        @(negedge clk);
        tx_done = 1'b0; irq_clr = '0;
        chk("R10 set wins", 32'(irq_pend), 32'h0040);
        do_clr(16'h0040);
        chk("R10 irq low", 32'(irq), 32'h0);

        // R12: tokens ignored mid-transaction; R8: timeout window
        send_tok(P_IN, MY_ADDR, 4'd5);
        chk("R4 ep5 data0", {27'b0, tx_start, tx_pid}, {27'b0, 1'b1, P_D0});
        send_tok(P_IN, MY_ADDR, 4'd2);
        chk("R12 busy ignore", 32'(tx_start), 32'h0);
        send_done();
        repeat (HS_TO) @(negedge clk);
        send_hs(P_ACK);
        chk("R8 late ack", {16'(irq_pend), 16'(ep_full & 16'h0020)}, {16'h0, 16'h0020});
        send_tok(P_IN, MY_ADDR, 4'd5);
        chk("R8 resend same pid", {27'b0, tx_start, tx_pid}, {27'b0, 1'b1, P_D0});
        send_done();
        repeat (HS_TO - 1) @(negedge clk);
        send_hs(P_ACK);
        chk("R8 last edge ack", {16'(irq_pend), 16'(ep_full & 16'h0020)}, {16'h0020, 16'h0});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule